// File: doc/BRIEF.md
# ADC Trigger and Window-Compare Controller

This block is the digital control that sits around a 10-bit successive-approximation converter. Software programs it through a small byte-wide register port. It holds an enable bit, a 3-bit code that selects which event starts a conversion, and two 10-bit limits. The limits are written as a low byte and a high byte each. When the selected event arrives, the block issues a one-cycle start pulse to the converter and raises a busy flag. It then waits for the converter's done strobe and captures the 10-bit result.

Each captured result is compared against the two limits. A match sets a sticky window flag, and that flag stays up until software clears it. A conversion can be started by a software write, by one of four timer overflow pulses, or by a rising edge on an external pin. The external pin is synchronised before edge detection. The analog mux, the track-and-hold and the bit-trial logic all live outside this block.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_start` and `win_flag` are 0 and `result` is 0. The block is disabled and the source code is 000.
- R2: While the enable bit (control register, address 0, bit 0) is 0, no trigger of any kind produces `conv_start`.
- R3: With the block enabled and source code 000, a write to address 0 with bit 4 set starts a conversion. The enable and source values used are the ones stored before that write.
- R4: Source code is control bits 3:1. Code 001 triggers on `tmr_ovf[0]`, 010 on `tmr_ovf[2]`, 011 on `tmr_ovf[1]` and 101 on `tmr_ovf[3]`. Codes 110 and 111 never trigger.
- R5: With code 100, `ext_start` passes through a two-flop synchroniser and triggers on its rising edge. A pin that rises before clock edge k gives `conv_start` high after edge k+2. A pin held high triggers only once.
- R6: A trigger seen at one clock edge makes `conv_start` high for exactly one cycle after that edge, and `busy` rises at the same edge.
- R7: While `busy` is 1, every trigger is ignored and no `conv_start` is produced.
- R8: When `busy` and `conv_done` are both 1 at an edge, `busy` clears and `result` takes `conv_data` at that edge. `conv_done` has no effect while `busy` is 0.
- R9: The greater-than limit G is at address 1 (bits 7:0) and address 2 (bits 9:8, in data bits 1:0). The less-than limit L is at addresses 3 and 4 in the same way. If L >= G, a result D matches when G <= D <= L. If L < G, D matches when D <= L or D >= G.
- R10: A matching result sets `win_flag`. A write to address 0 with bit 5 at 0 clears it, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| tmr_ovf | input | 4 | Timer overflow pulses, index = timer number |
| ext_start | input | 1 | Asynchronous external start pin |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | 10 | Converter result |
| conv_start | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last captured result |
| win_flag | output | 1 | Sticky window-match flag |

## Verification
The checker assumes three things about the inputs. First, `conv_data` is already valid in the cycle `conv_done` is asserted. Second, `tmr_ovf` bits are pulses rather than levels. Third, reset is held long enough for every input to reach a known value. The bench drives all inputs at the falling edge, raises timer bits for one cycle only, and presents the data together with the done strobe. It also issues done strobes while the block is idle and triggers while it is busy, so that the ignore paths are exercised without breaking those assumptions.

// File: rtl/adc_ctrl_pkg.sv
// Package: shared register map, control-bit positions and start-source codes
// for the ADC trigger/window controller. Assumes a byte-wide write port.
package adc_ctrl_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_GT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_GT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_LT_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_LT_HI = 3'd4;

    // Control register bit positions
    localparam int B_EN    = 0;
    localparam int B_SRC_L = 1;
    localparam int B_SRC_H = 3;
    localparam int B_GO    = 4;
    localparam int B_KEEP  = 5;

    typedef enum logic [2:0] {
        SRC_SOFT = 3'b000,
        SRC_TMR0 = 3'b001,
        SRC_TMR2 = 3'b010,
        SRC_TMR1 = 3'b011,
        SRC_EXT  = 3'b100,
        SRC_TMR3 = 3'b101,
        SRC_RSV6 = 3'b110,
        SRC_RSV7 = 3'b111
    } src_e;
endpackage

// File: rtl/adc_edge_sync.sv
// Module: adc_edge_sync
// Brings an asynchronous pin into the clock domain through STAGES flops and
// flags one cycle on each rising edge of the synchronised level.
// Assumes STAGES >= 2 and synchronous active-low reset.
module adc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchroniser chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= pin;
            last_q     <= chain_q[STAGES-1];
        end
    end

    // Remaining synchroniser stages
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    // Rising edge of the synchronised level
    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_trig_sel.sv
// Module: adc_trig_sel
// Picks the start event named by the source code. Purely combinational;
// assumes every event input is already a single-cycle pulse.
module adc_trig_sel
    import adc_ctrl_pkg::*;
#(
    parameter int N_TMR = 4
) (
    input  src_e             src,
    input  logic             soft_go,
    input  logic [N_TMR-1:0] tmr_ovf,
    input  logic             ext_rise,
    output logic             hit
);
    // Decode the source code to one event; reserved codes never fire
    always_comb begin
        unique case (src)
            SRC_SOFT: hit = soft_go;
            SRC_TMR0: hit = tmr_ovf[0];
            SRC_TMR2: hit = tmr_ovf[2];
            SRC_TMR1: hit = tmr_ovf[1];
            SRC_EXT:  hit = ext_rise;
            SRC_TMR3: hit = tmr_ovf[3];
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_win_cmp.sv
// Module: adc_win_cmp
// Window comparison of a result against a lower (greater-than) and upper
// (less-than) limit; when the limits cross, the test becomes out-of-window.
module adc_win_cmp #(
    parameter int W = 10
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] lim_gt,
    input  logic [W-1:0] lim_lt,
    output logic         match
);
    logic ge_gt, le_lt, crossed;

    // Two magnitude compares and the crossed-limit selection
    always_comb begin
        ge_gt   = (data >= lim_gt);
        le_lt   = (data <= lim_lt);
        crossed = (lim_lt < lim_gt);
        match   = crossed ? (ge_gt | le_lt) : (ge_gt & le_lt);
    end
endmodule

// File: rtl/adc_conv_ctrl.sv
// Module: adc_conv_ctrl (top)
// Register port, trigger gating, busy/start handshake with an external SAR
// converter, result capture and sticky window flag. Assumes conv_data is
// valid whenever conv_done is high, and timer inputs are pulses.
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int N_TMR       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [N_TMR-1:0]  tmr_ovf,
    input  logic              ext_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_start,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              win_flag
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic              en_q;
    src_e              src_q;
    logic [DATA_W-1:0] gt_q, lt_q;
    logic              ctrl_wr, soft_go, ext_rise, hit, fire, finish, match, clr;

    // Control-register write decode
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign soft_go = ctrl_wr && wr_data[B_GO];
    assign clr     = ctrl_wr && !wr_data[B_KEEP];

    adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_start),
        .rise (ext_rise)
    );

    adc_trig_sel #(.N_TMR(N_TMR)) u_sel (
        .src     (src_q),
        .soft_go (soft_go),
        .tmr_ovf (tmr_ovf),
        .ext_rise(ext_rise),
        .hit     (hit)
    );

    adc_win_cmp #(.W(DATA_W)) u_cmp (
        .data  (conv_data),
        .lim_gt(gt_q),
        .lim_lt(lt_q),
        .match (match)
    );

    // Start only when enabled and idle; finish only while busy
    assign fire   = en_q && !busy && hit;
    assign finish = busy && conv_done;

    // Configuration registers: enable, source and the two split limits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            src_q <= SRC_SOFT;
            gt_q  <= '0;
            lt_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    en_q  <= wr_data[B_EN];
                    src_q <= src_e'(wr_data[B_SRC_H:B_SRC_L]);
                end
                A_GT_LO: gt_q[BYTE_W-1:0]      <= wr_data;
                A_GT_HI: gt_q[DATA_W-1:BYTE_W] <= wr_data[HI_W-1:0];
                A_LT_LO: lt_q[BYTE_W-1:0]      <= wr_data;
                A_LT_HI: lt_q[DATA_W-1:BYTE_W] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Conversion handshake: start pulse, busy flag and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            busy       <= 1'b0;
            result     <= '0;
        end else begin
            conv_start <= fire;
            if (fire)        busy <= 1'b1;
            else if (finish) busy <= 1'b0;
            if (finish)      result <= conv_data;
        end
    end

    // Sticky window flag; a new match wins over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)               win_flag <= 1'b0;
        else if (finish && match) win_flag <= 1'b1;
        else if (clr)             win_flag <= 1'b0;
    end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
// Module: adc_conv_ctrl_chk
// Temporal checks on the controller's handshake and flags, bound to the top.
module adc_conv_ctrl_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_q,
    input logic [2:0]        src_q,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              conv_done,
    input logic [DATA_W-1:0] conv_data,
    input logic              conv_start,
    input logic              busy,
    input logic [DATA_W-1:0] result,
    input logic              win_flag
);
    assert_off_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !conv_start);

    assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q[2:1] == 2'b11) |=> !conv_start);

    assert_start_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    assert_start_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> (busy && !conv_start));

    assert_done_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> (!busy && result == $past(conv_data)));

    assert_idle_done_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && conv_done) |=> $stable(result));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_flag && !(wr_en && wr_addr == 3'd0 && !wr_data[5])) |=> win_flag);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .src_q     (src_q),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .conv_start(conv_start),
    .busy      (busy),
    .result    (result),
    .win_flag  (win_flag)
);

// File: tb/adc_conv_ctrl_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module adc_conv_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] tmr_ovf = '0;
    logic       ext_start = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       conv_start, busy, win_flag;
    logic [9:0] result;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    adc_conv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tmr_ovf(tmr_ovf), .ext_start(ext_start), .conv_done(conv_done),
        .conv_data(conv_data), .conv_start(conv_start), .busy(busy),
        .result(result), .win_flag(win_flag)
    );

    // Reference model state
    int m_en, m_src, m_gt, m_lt, m_busy, m_start, m_res, m_flag;
    int m_p1, m_p2, m_pl;

    function automatic int in_window(int d, int g, int l);
        if (l >= g) return (d >= g && d <= l) ? 1 : 0;
        return (d <= l || d >= g) ? 1 : 0;
    endfunction

    // Model update at each rising edge, from the inputs held since the falling edge
    always @(posedge clk) begin
        int hit, trig, done, rise;
        if (!rst_n) begin
            m_en = 0; m_src = 0; m_gt = 0; m_lt = 0; m_busy = 0; m_start = 0;
            m_res = 0; m_flag = 0; m_p1 = 0; m_p2 = 0; m_pl = 0;
        end else begin
            rise = (m_p2 == 1 && m_pl == 0) ? 1 : 0;
            case (m_src)
                0: hit = (wr_en && wr_addr == 0 && wr_data[4]) ? 1 : 0;
                1: hit = tmr_ovf[0];
                2: hit = tmr_ovf[2];
                3: hit = tmr_ovf[1];
                4: hit = rise;
                5: hit = tmr_ovf[3];
                default: hit = 0;
            endcase
            trig = (m_en && !m_busy && hit) ? 1 : 0;
            done = (m_busy && conv_done) ? 1 : 0;
            m_start = trig;
            if (trig) m_busy = 1; else if (done) m_busy = 0;
            if (done && in_window(int'(conv_data), m_gt, m_lt)) m_flag = 1;
            else if (wr_en && wr_addr == 0 && !wr_data[5]) m_flag = 0;
            if (done) m_res = int'(conv_data);
            if (wr_en) case (wr_addr)
                0: begin m_en = wr_data[0]; m_src = int'(wr_data[3:1]); end
                1: m_gt = (m_gt & 'h300) | int'(wr_data);
                2: m_gt = (m_gt & 'hFF) | (int'(wr_data[1:0]) << 8);
                3: m_lt = (m_lt & 'h300) | int'(wr_data);
                4: m_lt = (m_lt & 'hFF) | (int'(wr_data[1:0]) << 8);
                default: ;
            endcase
            m_pl = m_p2; m_p2 = m_p1; m_p1 = ext_start;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) if (rst_n) begin
        check(conv_start == m_start[0], "R6 conv_start", conv_start, m_start);
        check(busy == m_busy[0], "R7 busy", busy, m_busy);
        check(int'(result) == m_res, "R8 result", result, m_res);
        check(win_flag == m_flag[0], "R10 win_flag", win_flag, m_flag);
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic ctrl(input int en, input int src, input int go, input int keep);
        wr(0, en | (src << 1) | (go << 4) | (keep << 5));
    endtask

    task automatic limits(input int g, input int l);
        wr(1, g & 'hFF); wr(2, g >> 8); wr(3, l & 'hFF); wr(4, l >> 8);
    endtask

    task automatic tpulse(input int idx);
        @(negedge clk); tmr_ovf = 4'(1 << idx);
        @(negedge clk); tmr_ovf = 0;
    endtask

    task automatic finish_conv(input int d);
        @(negedge clk); conv_done = 1; conv_data = 10'(d);
        @(negedge clk); conv_done = 0;
    endtask

    task automatic run_soft(input int d, input int expf, input string tag);
        ctrl(1, 0, 1, 1);
        check(conv_start == 1, "R3 soft start", conv_start, 1);
        finish_conv(d);
        check(win_flag == expf[0], tag, win_flag, expf);
        ctrl(1, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int tcode[4] = '{1, 3, 2, 5};
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(busy == 0 && conv_start == 0 && win_flag == 0 && result == 0, "R1 reset", busy, 0);

        // Disabled: software start ignored
        ctrl(0, 0, 1, 1);
        check(conv_start == 0 && busy == 0, "R2 disabled soft", conv_start, 0);

        // Window in-range, edges, outside
        limits(100, 500);
        ctrl(1, 0, 0, 1);
        run_soft(300, 1, "R9 inside");
        run_soft(100, 1, "R9 at G");
        run_soft(500, 1, "R9 at L");
        run_soft(99, 0, "R9 below G");
        run_soft(501, 0, "R9 above L");

        // Idle done ignored
        finish_conv(77);
        check(result == 501, "R8 idle done", result, 501);

        // Busy ignores a second trigger
        ctrl(1, 0, 1, 1);
        ctrl(1, 0, 1, 1);
        check(conv_start == 0 && busy == 1, "R7 retrigger", conv_start, 0);
        finish_conv(300);
        check(busy == 0 && result == 300, "R8 done", result, 300);

        // Sticky flag and clear
        ctrl(1, 0, 0, 1);
        check(win_flag == 1, "R10 keep", win_flag, 1);
        ctrl(1, 0, 0, 0);
        check(win_flag == 0, "R10 clear", win_flag, 0);

        // Timer sources: wrong timers ignored, right one fires
        for (int k = 0; k < 4; k++) begin
            ctrl(1, tcode[k], 0, 1);
            for (int j = 0; j < 4; j++) if (j != k) begin
                tpulse(j);
                check(conv_start == 0, "R4 other timer", conv_start, 0);
            end
            tpulse(k);
            check(conv_start == 1, "R4 selected timer", conv_start, 0);
            finish_conv(k);
        end

        // Reserved codes
        for (int c = 6; c < 8; c++) begin
            ctrl(1, c, 1, 1);
            for (int j = 0; j < 4; j++) begin
                tpulse(j);
                check(conv_start == 0 && busy == 0, "R4 reserved", conv_start, 0);
            end
        end

        // Disabled with a timer source
        ctrl(0, 1, 0, 1);
        tpulse(0);
        check(busy == 0, "R2 disabled timer", busy, 0);

        // External pin timing
        ctrl(1, 4, 0, 1);
        @(negedge clk); ext_start = 1;
        @(negedge clk); check(conv_start == 0, "R5 ext early", conv_start, 0);
        @(negedge clk); check(conv_start == 0, "R5 ext early", conv_start, 0);
        @(negedge clk); check(conv_start == 1, "R5 ext start", conv_start, 1);
        finish_conv(10);
        repeat (5) @(negedge clk);
        check(busy == 0, "R5 level no retrigger", busy, 0);
        ext_start = 0;
        repeat (4) @(negedge clk);

        // Crossed limits: out-of-window match
        ctrl(1, 0, 0, 0);
        limits(600, 200);
        run_soft(100, 1, "R9 crossed low");
        run_soft(400, 0, "R9 crossed mid");
        run_soft(700, 1, "R9 crossed high");

        // Set wins over a same-cycle clear
        ctrl(1, 0, 1, 1);
        @(negedge clk); conv_done = 1; conv_data = 10'd150;
        wr_en = 1; wr_addr = 0; wr_data = 8'h01;
        @(negedge clk); conv_done = 0; wr_en = 0;
        check(win_flag == 1, "R10 set wins", win_flag, 1);

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule